// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block chooses the fastest DMA transfer mode that both a drive and its host controller can run. It looks at the capability fields of the drive's identify data, at per-class capability masks of the host, at the media type and at the cable type. A requested ceiling caps the choice. Three mode classes are searched: ultra DMA, then multiword DMA, then single-word DMA. The first class that offers any usable mode supplies the result. If no class offers one, the result is zero, which means no DMA.

A request strobe starts one evaluation. One clock later a done pulse marks two registered outputs: the mode code, and a flag that reports identify data that contradicts itself. Both outputs hold their values until the next request. The identify words reach the block split into fields. The low bits of each word carry the modes the drive supports. The upper byte carries the mode that is currently selected, and only the consistency check reads it.

Top module: `dma_mode_sel`

## Requirements
- R1: After reset, `done`, `mode_out` and `id_err` are 0. A `req_valid` high at a clock edge makes `done` high for exactly the following cycle, with `mode_out` and `id_err` updated at that edge. Without `req_valid`, `done` is 0 and both outputs hold their values.
- R2: When `media_not_disk` and `host_no_atapi_dma` are both 1, the mode result is 0, whatever the masks hold.
- R3: Mode codes are the class base plus a mode number. The bases are 0x40 for ultra, 0x20 for multiword and 0x10 for single-word. The classes are searched in that order, and a class is skipped when `req_mode` is below its base. A request below 0x10 yields 0.
- R4: Within a class, the mode number is the index of the highest set bit of that class's combined mask. The first class with a nonzero mask supplies the result.
- R5: The ultra mask is `host_udma_mask & id_udma_sup`. It is zero unless validity bit 2 (`id_field_valid[2]`) is 1.
- R6: When `req_mode` is above 0x42, the ultra mask has any of bits 3 and up set, and `cable_80w` is 0, the ultra mask is cut to bits 0 to 2. A request of 0x42 or less never triggers the cut.
- R7: The multiword mask is `host_mw_mask & id_mw_sup`. It is zero unless validity bit 1 (`id_field_valid[1]`) is 1.
- R8: The single-word mask depends on validity bit 1. With the bit at 1, the mask is `host_sw_mask & id_sw_sup`. With the bit at 0, it is taken from `id_legacy_tmg`: a value of 1 gives 0b011, a value of 2 gives 0b111, and each is ANDed with `host_sw_mask`. A value of 0 or above 2 gives an empty mask.
- R9: The reported mode is the smaller of the selected mode and `req_mode`.
- R10: `id_err` is 1 in two cases. With validity bit 2 at 1, it is 1 when `id_udma_sel` and `id_mw_sel` are both nonzero. With validity bit 2 at 0 and bit 1 at 1, it is 1 when `id_mw_sel` and `id_sw_sel` are both nonzero. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Starts one evaluation |
| req_mode | input | 8 | Highest mode code allowed |
| id_field_valid | input | 2 ([2:1]) | Identify validity bits: bit 1 for the multiword and single-word words, bit 2 for the ultra word |
| id_udma_sup | input | UDMA_W (7) | Ultra modes the drive supports |
| id_udma_sel | input | 8 | Upper byte of the ultra word |
| id_mw_sup | input | MW_W (3) | Multiword modes the drive supports |
| id_mw_sel | input | 8 | Upper byte of the multiword word |
| id_sw_sup | input | SW_W (3) | Single-word modes the drive supports |
| id_sw_sel | input | 8 | Upper byte of the single-word word |
| id_legacy_tmg | input | 8 | Legacy single-word timing mode value |
| host_udma_mask | input | UDMA_W (7) | Ultra modes the host supports |
| host_mw_mask | input | MW_W (3) | Multiword modes the host supports |
| host_sw_mask | input | SW_W (3) | Single-word modes the host supports |
| media_not_disk | input | 1 | Drive is not a disk |
| host_no_atapi_dma | input | 1 | Host forbids DMA for non-disk drives |
| cable_80w | input | 1 | 80-wire cable detected |
| done | output | 1 | One-cycle pulse: results are valid |
| mode_out | output | 8 | Chosen mode code, 0 for no DMA |
| id_err | output | 1 | Identify data is inconsistent |

## Verification
Each result is due exactly one clock after the edge that samples `req_valid`: the mode, the error flag and the done pulse all come from a single register stage. The bench raises the strobe on a falling edge and lowers it on the next falling edge. By then the capturing rising edge has passed, so it reads the outputs and `done` at that point. One more falling edge later, it checks that `done` has dropped and that the outputs still hold. The hold check also runs after the inputs have changed with no strobe, which shows that the outputs move only on a request.

// File: rtl/dmasel_pkg.sv
package dmasel_pkg;

   localparam int MODE_W = 8;
   typedef logic [MODE_W-1:0] mode_t;

   typedef enum logic [1:0] {
      CLS_UDMA = 2'd0,
      CLS_MW   = 2'd1,
      CLS_SW   = 2'd2
   } cls_e;

   localparam mode_t BASE_UDMA      = 8'h40;
   localparam mode_t BASE_MW        = 8'h20;
   localparam mode_t BASE_SW        = 8'h10;
   // highest ultra mode code usable without an 80-wire cable
   localparam mode_t UDMA_CAP_LIMIT = 8'h42;
   localparam int    UDMA_LOW_MODES = 3;

   function automatic mode_t class_base(input cls_e c);
      case (c)
         CLS_UDMA: class_base = BASE_UDMA;
         CLS_MW:   class_base = BASE_MW;
         default:  class_base = BASE_SW;
      endcase
   endfunction

   function automatic mode_t mode_min(input mode_t a, input mode_t b);
      mode_min = (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/dmasel_udma_mask.sv
module dmasel_udma_mask
   import dmasel_pkg::*;
#(
   parameter int W = 7
) (
   input  logic         en,
   input  logic [W-1:0] host_mask,
   input  logic [W-1:0] drive_sup,
   input  mode_t        req_mode,
   input  logic         cable_80w,
   output logic [W-1:0] mask
);

   localparam logic [W-1:0] KEEP_LOW = W'((1 << UDMA_LOW_MODES) - 1);

   if (W <= UDMA_LOW_MODES) begin : g_bad_width
      $error("dmasel_udma_mask: W must exceed the low ultra mode count");
   end

   logic [W-1:0] raw;
   logic         fast_modes;
   logic         cut;

   always_comb begin
      raw        = host_mask & drive_sup;
      fast_modes = |raw[W-1:UDMA_LOW_MODES];
      cut        = (req_mode > UDMA_CAP_LIMIT) && fast_modes && !cable_80w;
      if (!en)
         mask = '0;
      else if (cut)
         mask = raw & KEEP_LOW;
      else
         mask = raw;
   end

endmodule

// File: rtl/dmasel_sw_mask.sv
module dmasel_sw_mask #(
   parameter int W = 3
) (
   input  logic         word_ok,
   input  logic [W-1:0] host_mask,
   input  logic [W-1:0] drive_sup,
   input  logic [7:0]   legacy_tmg,
   output logic [W-1:0] mask
);

   if (W < 3) begin : g_bad_width
      $error("dmasel_sw_mask: W must cover three legacy modes");
   end

   logic [3:0] span;
   logic       tmg_ok;

   always_comb begin
      span   = (4'd2 << legacy_tmg[1:0]) - 4'd1;
      tmg_ok = (legacy_tmg == 8'd1) || (legacy_tmg == 8'd2);
      if (word_ok)
         mask = host_mask & drive_sup;
      else if (tmg_ok)
         mask = host_mask & W'(span);
      else
         mask = '0;
   end

endmodule

// File: rtl/dmasel_msb.sv
module dmasel_msb #(
   parameter int W  = 7,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) idx = IW'(i);
      end
      found = |vec;
   end

endmodule

// File: rtl/dmasel_id_check.sv
module dmasel_id_check (
   input  logic       udma_word_ok,
   input  logic       mw_word_ok,
   input  logic [7:0] udma_sel,
   input  logic [7:0] mw_sel,
   input  logic [7:0] sw_sel,
   output logic       bad
);

   always_comb begin
      if (udma_word_ok)
         bad = (|udma_sel) && (|mw_sel);
      else if (mw_word_ok)
         bad = (|mw_sel) && (|sw_sel);
      else
         bad = 1'b0;
   end

endmodule

// File: rtl/dma_mode_sel.sv
module dma_mode_sel
   import dmasel_pkg::*;
#(
   parameter int UDMA_W = 7,
   parameter int MW_W   = 3,
   parameter int SW_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [7:0]        req_mode,
   input  logic [2:1]        id_field_valid,
   input  logic [UDMA_W-1:0] id_udma_sup,
   input  logic [7:0]        id_udma_sel,
   input  logic [MW_W-1:0]   id_mw_sup,
   input  logic [7:0]        id_mw_sel,
   input  logic [SW_W-1:0]   id_sw_sup,
   input  logic [7:0]        id_sw_sel,
   input  logic [7:0]        id_legacy_tmg,
   input  logic [UDMA_W-1:0] host_udma_mask,
   input  logic [MW_W-1:0]   host_mw_mask,
   input  logic [SW_W-1:0]   host_sw_mask,
   input  logic              media_not_disk,
   input  logic              host_no_atapi_dma,
   input  logic              cable_80w,
   output logic              done,
   output logic [7:0]        mode_out,
   output logic              id_err
);

   localparam int UIW = (UDMA_W > 1) ? $clog2(UDMA_W) : 1;
   localparam int MIW = (MW_W > 1) ? $clog2(MW_W) : 1;
   localparam int SIW = (SW_W > 1) ? $clog2(SW_W) : 1;

   if (UDMA_W < 4 || UDMA_W > 8) begin : g_bad_udma
      $error("dma_mode_sel: UDMA_W must be 4..8");
   end
   if (MW_W < 1 || MW_W > 8) begin : g_bad_mw
      $error("dma_mode_sel: MW_W must be 1..8");
   end
   if (SW_W < 3 || SW_W > 8) begin : g_bad_sw
      $error("dma_mode_sel: SW_W must be 3..8");
   end

   // ---------------- per-class masks ----------------
   logic [UDMA_W-1:0] udma_mask;
   logic [MW_W-1:0]   mw_mask;
   logic [SW_W-1:0]   sw_mask;

   dmasel_udma_mask #(.W(UDMA_W)) u_udma_mask (
      .en        (id_field_valid[2]),
      .host_mask (host_udma_mask),
      .drive_sup (id_udma_sup),
      .req_mode  (req_mode),
      .cable_80w (cable_80w),
      .mask      (udma_mask)
   );

   assign mw_mask = id_field_valid[1] ? (host_mw_mask & id_mw_sup) : '0;

   dmasel_sw_mask #(.W(SW_W)) u_sw_mask (
      .word_ok    (id_field_valid[1]),
      .host_mask  (host_sw_mask),
      .drive_sup  (id_sw_sup),
      .legacy_tmg (id_legacy_tmg),
      .mask       (sw_mask)
   );

   // ---------------- highest mode per class ----------------
   logic           udma_found, mw_found, sw_found;
   logic [UIW-1:0] udma_idx;
   logic [MIW-1:0] mw_idx;
   logic [SIW-1:0] sw_idx;

   dmasel_msb #(.W(UDMA_W), .IW(UIW)) u_udma_msb (
      .vec(udma_mask), .found(udma_found), .idx(udma_idx)
   );
   dmasel_msb #(.W(MW_W), .IW(MIW)) u_mw_msb (
      .vec(mw_mask), .found(mw_found), .idx(mw_idx)
   );
   dmasel_msb #(.W(SW_W), .IW(SIW)) u_sw_msb (
      .vec(sw_mask), .found(sw_found), .idx(sw_idx)
   );

   // ---------------- class priority and clamp ----------------
   mode_t picked;
   mode_t result;
   logic  atapi_block;

   always_comb begin
      atapi_block = media_not_disk && host_no_atapi_dma;
      picked      = '0;
      if (!atapi_block) begin
         if (req_mode >= class_base(CLS_UDMA) && udma_found)
            picked = class_base(CLS_UDMA) + mode_t'(udma_idx);
         else if (req_mode >= class_base(CLS_MW) && mw_found)
            picked = class_base(CLS_MW) + mode_t'(mw_idx);
         else if (req_mode >= class_base(CLS_SW) && sw_found)
            picked = class_base(CLS_SW) + mode_t'(sw_idx);
      end
      result = mode_min(picked, req_mode);
   end

   // ---------------- identify consistency ----------------
   logic id_bad;

   dmasel_id_check u_id_check (
      .udma_word_ok (id_field_valid[2]),
      .mw_word_ok   (id_field_valid[1]),
      .udma_sel     (id_udma_sel),
      .mw_sel       (id_mw_sel),
      .sw_sel       (id_sw_sel),
      .bad          (id_bad)
   );

   // ---------------- result register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         mode_out <= '0;
         id_err   <= 1'b0;
      end else begin
         done <= req_valid;
         if (req_valid) begin
            mode_out <= result;
            id_err   <= id_bad;
         end
      end
   end

endmodule

// File: rtl/dmasel_checker.sv
module dmasel_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [7:0] req_mode,
   input logic       media_not_disk,
   input logic       host_no_atapi_dma,
   input logic       cable_80w,
   input logic       done,
   input logic [7:0] mode_out,
   input logic       id_err
);

   p_done_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> done);

   p_done_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !done);

   p_hold_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(mode_out) && $stable(id_err));

   p_atapi_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && media_not_disk && host_no_atapi_dma |=> mode_out == 8'h00);

   p_class_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done && mode_out != 8'h00 |->
         (mode_out[7:4] == 4'h1 || mode_out[7:4] == 4'h2 || mode_out[7:4] == 4'h4));

   p_cable_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !cable_80w |=> mode_out <= 8'h42);

   p_not_above_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> mode_out <= $past(req_mode));

endmodule

bind dma_mode_sel dmasel_checker u_dmasel_checker (
   .clk               (clk),
   .rst_n             (rst_n),
   .req_valid         (req_valid),
   .req_mode          (req_mode),
   .media_not_disk    (media_not_disk),
   .host_no_atapi_dma (host_no_atapi_dma),
   .cable_80w         (cable_80w),
   .done              (done),
   .mode_out          (mode_out),
   .id_err            (id_err)
);

// File: tb/dma_mode_sel_bench.sv
module dma_mode_sel_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [7:0] req_mode;
   logic [2:1] id_field_valid;
   logic [6:0] id_udma_sup;
   logic [7:0] id_udma_sel;
   logic [2:0] id_mw_sup;
   logic [7:0] id_mw_sel;
   logic [2:0] id_sw_sup;
   logic [7:0] id_sw_sel;
   logic [7:0] id_legacy_tmg;
   logic [6:0] host_udma_mask;
   logic [2:0] host_mw_mask;
   logic [2:0] host_sw_mask;
   logic       media_not_disk;
   logic       host_no_atapi_dma;
   logic       cable_80w;
   logic       done;
   logic [7:0] mode_out;
   logic       id_err;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dma_mode_sel u_dma_mode_sel (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .id_field_valid(id_field_valid), .id_udma_sup(id_udma_sup),
      .id_udma_sel(id_udma_sel), .id_mw_sup(id_mw_sup), .id_mw_sel(id_mw_sel),
      .id_sw_sup(id_sw_sup), .id_sw_sel(id_sw_sel), .id_legacy_tmg(id_legacy_tmg),
      .host_udma_mask(host_udma_mask), .host_mw_mask(host_mw_mask),
      .host_sw_mask(host_sw_mask), .media_not_disk(media_not_disk),
      .host_no_atapi_dma(host_no_atapi_dma), .cable_80w(cable_80w),
      .done(done), .mode_out(mode_out), .id_err(id_err)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic defaults();
      req_mode          = 8'h46;
      id_field_valid    = 2'b11;
      id_udma_sup       = '0;
      id_udma_sel       = '0;
      id_mw_sup         = '0;
      id_mw_sel         = '0;
      id_sw_sup         = '0;
      id_sw_sel         = '0;
      id_legacy_tmg     = '0;
      host_udma_mask    = 7'h7f;
      host_mw_mask      = 3'h7;
      host_sw_mask      = 3'h7;
      media_not_disk    = 1'b0;
      host_no_atapi_dma = 1'b0;
      cable_80w         = 1'b1;
   endtask

   // strobe on a falling edge; result due after the next rising edge
   task automatic fire(input string tag, input logic [7:0] exp_mode, input logic exp_err);
      @(negedge clk);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " done R1"}, {7'd0, done}, 8'h01);
      chk({tag, " mode"}, mode_out, exp_mode);
      chk({tag, " id_err"}, {7'd0, id_err}, {7'd0, exp_err});
      @(negedge clk);
      chk({tag, " done drop R1"}, {7'd0, done}, 8'h00);
   endtask

   task automatic t_reset_r1();
      chk("reset done R1", {7'd0, done}, 8'h00);
      chk("reset mode R1", mode_out, 8'h00);
      chk("reset id_err R1", {7'd0, id_err}, 8'h00);
   endtask

   task automatic t_ultra_r4_r5();
      defaults(); id_udma_sup = 7'h3f;
      fire("R4 R5 ultra top bit 5", 8'h45, 1'b0);
      defaults(); id_udma_sup = 7'h7f;
      fire("R4 R5 ultra all", 8'h46, 1'b0);
      defaults(); id_udma_sup = 7'h7f; host_udma_mask = 7'h05;
      fire("R5 host limits ultra", 8'h42, 1'b0);
      defaults(); id_field_valid = 2'b01; id_udma_sup = 7'h7f; id_mw_sup = 3'h4;
      fire("R5 ultra ignored without bit 2", 8'h22, 1'b0);
   endtask

   task automatic t_cable_r6();
      defaults(); id_udma_sup = 7'h3f; cable_80w = 1'b0;
      fire("R6 cable cut", 8'h42, 1'b0);
      defaults(); id_udma_sup = 7'h18; id_mw_sup = 3'h7; cable_80w = 1'b0;
      fire("R6 cut empties ultra falls to multiword", 8'h22, 1'b0);
      defaults(); id_udma_sup = 7'h18; id_mw_sup = 3'h7; cable_80w = 1'b0; req_mode = 8'h42;
      fire("R6 no cut at request 0x42", 8'h42, 1'b0);
   endtask

   task automatic t_order_r3_r7();
      defaults(); id_udma_sup = 7'h7f; id_mw_sup = 3'h7; req_mode = 8'h22;
      fire("R3 ultra skipped below base", 8'h22, 1'b0);
      defaults(); id_udma_sup = 7'h7f; id_mw_sup = 3'h3; req_mode = 8'h22;
      fire("R3 R7 multiword mode 1", 8'h21, 1'b0);
      defaults(); id_udma_sup = 7'h7f; id_mw_sup = 3'h7; id_sw_sup = 3'h7; req_mode = 8'h0c;
      fire("R3 request below all bases", 8'h00, 1'b0);
      defaults(); id_field_valid = 2'b10; id_mw_sup = 3'h7; id_legacy_tmg = 8'd2;
      fire("R7 multiword ignored without bit 1", 8'h12, 1'b0);
   endtask

   task automatic t_single_r8();
      defaults(); id_sw_sup = 3'h2;
      fire("R8 single-word drive word", 8'h11, 1'b0);
      defaults(); id_field_valid = 2'b00; id_legacy_tmg = 8'd1;
      fire("R8 legacy timing 1", 8'h11, 1'b0);
      defaults(); id_field_valid = 2'b00; id_legacy_tmg = 8'd2; host_sw_mask = 3'h3;
      fire("R8 legacy timing 2 host cap", 8'h11, 1'b0);
      defaults(); id_field_valid = 2'b00; id_legacy_tmg = 8'd0;
      fire("R8 legacy timing 0", 8'h00, 1'b0);
      defaults(); id_field_valid = 2'b00; id_legacy_tmg = 8'd3;
      fire("R8 legacy timing 3", 8'h00, 1'b0);
   endtask

   task automatic t_clamp_r9();
      defaults(); id_udma_sup = 7'h3f; req_mode = 8'h44;
      fire("R9 clamp to request", 8'h44, 1'b0);
   endtask

   task automatic t_atapi_r2();
      defaults(); id_udma_sup = 7'h7f; id_mw_sup = 3'h7; id_sw_sup = 3'h7;
      media_not_disk = 1'b1; host_no_atapi_dma = 1'b1;
      fire("R2 non-disk blocked", 8'h00, 1'b0);
      defaults(); id_udma_sup = 7'h3f; media_not_disk = 1'b1;
      fire("R2 non-disk allowed", 8'h45, 1'b0);
   endtask

   task automatic t_id_err_r10();
      defaults(); id_field_valid = 2'b10; id_udma_sel = 8'h01; id_mw_sel = 8'h01;
      fire("R10 ultra and multiword both selected", 8'h00, 1'b1);
      defaults(); id_field_valid = 2'b01; id_mw_sel = 8'h04; id_sw_sel = 8'h02;
      fire("R10 multiword and single both selected", 8'h00, 1'b1);
      defaults(); id_mw_sel = 8'h04; id_sw_sel = 8'h02;
      fire("R10 bit 2 set overrides word pair", 8'h00, 1'b0);
   endtask

   task automatic t_hold_r1();
      defaults(); id_udma_sup = 7'h3f; id_udma_sel = 8'h01; id_mw_sel = 8'h01;
      fire("R1 hold setup", 8'h45, 1'b1);
      id_udma_sup = 7'h01; id_udma_sel = 8'h00;
      repeat (3) @(negedge clk);
      chk("R1 hold mode", mode_out, 8'h45);
      chk("R1 hold id_err", {7'd0, id_err}, 8'h01);
      chk("R1 hold done", {7'd0, done}, 8'h00);
   endtask

   initial begin
      defaults();
      repeat (3) @(negedge clk);
      t_reset_r1();
      rst_n = 1'b1;
      @(negedge clk);
      t_ultra_r4_r5();
      t_cable_r6();
      t_order_r3_r7();
      t_single_r8();
      t_clamp_r9();
      t_atapi_r2();
      t_id_err_r10();
      t_hold_r1();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule